// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the control state for a set of 8-bit general purpose I/O ports. The default is two ports, which gives sixteen pins. Each port has three writable bytes: the drive level, the read inversion mask and the direction. A fourth, read-only view returns the pin levels. The pins pass through a two-flop synchronizer. A read of a port's input view captures that byte of the synchronized pins, XORed with the port's inversion mask, into a registered read-data byte. All bytes of the port are taken on the same edge, so the returned byte is coherent.

A serial bus slave or any local controller can drive the bank. It accesses the bank through a single-cycle write strobe, a single-cycle read strobe and a small address. The upper two address bits select the register kind: 0 is input, 1 is drive level, 2 is inversion and 3 is direction. The low bit selects the port. The pad ring takes `pin_out` and `pin_oe` directly.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit is 1, every drive-level bit is 1 and every inversion bit is 0. As a result, `pin_oe` is all zeros and `pin_out` is all ones.
- R2: A direction bit of 0 turns on the output enable of its pin, and a direction bit of 1 turns it off. Writing a direction byte changes `pin_oe` on the next cycle.
- R3: `pin_out` of each pin equals the stored drive-level bit, one cycle after that byte is written.
- R4: A read at address 0 returns synchronized pins 7..0, and a read at address 1 returns pins 15..8. Each bit is XORed with the matching inversion bit: a 1 inverts the bit and a 0 leaves it unchanged.
- R5: The input view shows the pin level whatever the direction of the pin.
- R6: Reading a drive-level byte (address 2 or 3) returns the stored value, not the pin level.
- R7: Writes to address 0 or 1 change nothing: `pin_out`, `pin_oe` and every stored byte keep their values.
- R8: Each byte is written independently. A write to one address leaves the other ports and the other kinds unchanged.
- R9: `rdata` is updated on the clock edge that samples `rd_en`, and it holds its value while `rd_en` is low.
- R10: Pins pass through two flops before they are read. A read sampled on the first or second edge after a pin change returns the old level. A read on the third edge or later returns the new level.
- R11: Reading an inversion byte (address 4 or 5) or a direction byte (address 6 or 7) returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | {kind[1:0], port} register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Drive level per pin |
| pin_oe | output | 16 | Output enable per pin, active high |

## Verification
The case hardest to reach from the ports is the synchronizer window. A read has to land on exactly the first, second or third edge after a pin change. The bench changes `pin_in` on the falling edge on which it raises `rd_en`, reads again two edges later, and compares the old and the new levels. Other hard cases are ignored writes to the input view and cross-byte independence. These are shown by reading every stored byte back and watching both pin buses after each write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    KIND_IN  = 2'd0,
    KIND_OUT = 2'd1,
    KIND_POL = 2'd2,
    KIND_DIR = 2'd3
  } reg_kind_e;

  // Returned input byte: pin level XOR inversion mask.
  function automatic logic [7:0] apply_polarity(input logic [7:0] lvl,
                                                input logic [7:0] inv);
    return lvl ^ inv;
  endfunction

  // Output enable from a direction byte (1 = input, driver off).
  function automatic logic [7:0] dir_to_oe(input logic [7:0] dir);
    return ~dir;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PORTS  = 2,
  parameter int BW     = 8,
  parameter int PSEL_W = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_kind_e           wr_kind,
  input  logic [PSEL_W-1:0]   wr_port,
  input  logic [BW-1:0]       wdata,
  output logic [PORTS*BW-1:0] out_q,
  output logic [PORTS*BW-1:0] pol_q,
  output logic [PORTS*BW-1:0] dir_q
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (wr_port == PSEL_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[p*BW +: BW] <= '1;
        pol_q[p*BW +: BW] <= '0;
        dir_q[p*BW +: BW] <= '1;
      end else if (hit) begin
        case (wr_kind)
          KIND_OUT: out_q[p*BW +: BW] <= wdata;
          KIND_POL: pol_q[p*BW +: BW] <= wdata;
          KIND_DIR: dir_q[p*BW +: BW] <= wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PORTS = 2,
  parameter int BW    = 8,
  localparam int NPIN   = PORTS * BW,
  localparam int PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int AW     = 2 + PSEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [BW-1:0]   wdata,
  output logic [BW-1:0]   rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  reg_kind_e           acc_kind;
  logic [PSEL_W-1:0]   acc_port;
  logic [NPIN-1:0]     pins_s;
  logic [NPIN-1:0]     out_q, pol_q, dir_q;
  logic [BW-1:0]       rd_next;
  logic                wr_ignored;

  assign acc_kind   = reg_kind_e'(addr[AW-1 -: 2]);
  assign acc_port   = addr[PSEL_W-1:0];
  assign wr_ignored = wr_en && (acc_kind == KIND_IN);

  gpio_pin_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s)
  );

  gpio_port_regs #(.PORTS(PORTS), .BW(BW), .PSEL_W(PSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(acc_kind),
    .wr_port(acc_port), .wdata(wdata),
    .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_pad
    assign pin_out[p*BW +: BW] = out_q[p*BW +: BW];
    assign pin_oe[p*BW +: BW]  = dir_to_oe(dir_q[p*BW +: BW]);
  end

  always_comb begin
    case (acc_kind)
      KIND_IN:  rd_next = apply_polarity(pins_s[acc_port*BW +: BW],
                                         pol_q[acc_port*BW +: BW]);
      KIND_OUT: rd_next = out_q[acc_port*BW +: BW];
      KIND_POL: rd_next = pol_q[acc_port*BW +: BW];
      default:  rd_next = dir_q[acc_port*BW +: BW];
    endcase
  end

  // All bytes of the input view are captured on the edge that samples rd_en.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_kind == KIND_DIR && acc_port == '0) |=> (pin_oe[BW-1:0] == ~$past(wdata))); // R2
  AST_OUT_TO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_kind == KIND_OUT && acc_port == '0) |=> (pin_out[BW-1:0] == $past(wdata))); // R3
  AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> ($stable(pin_out) && $stable(pin_oe))); // R7
  AST_BYTE_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_port != '0) |=> ($stable(pin_out[BW-1:0]) && $stable(pin_oe[BW-1:0]))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_out, pin_oe;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 oe", pin_oe, 16'h0000);
    check("R1 out", pin_out, 16'hFFFF);
    rd(3'd2, d); check("R1 out0 read", d, 8'hFF);
    rd(3'd7, d); check("R1 dir1 read", d, 8'hFF);
    rd(3'd5, d); check("R1 pol1 read", d, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    wr(3'd6, 8'h0F); check("R2 oe after dir0", pin_oe, 16'h00F0);
    wr(3'd7, 8'h00); check("R2/R8 oe after dir1", pin_oe, 16'hFFF0);
    rd(3'd6, d); check("R11 dir0 read", d, 8'h0F);
  endtask

  task automatic t_output();
    logic [7:0] d;
    wr(3'd2, 8'hA5); check("R3 out0", pin_out, 16'hFFA5);
    wr(3'd3, 8'h3C); check("R3/R8 out1", pin_out, 16'h3CA5);
    pin_in = 16'h0000; settle();
    rd(3'd2, d); check("R6 out0 read is flop", d, 8'hA5);
    rd(3'd3, d); check("R6 out1 read is flop", d, 8'h3C);
  endtask

  task automatic t_input();
    logic [7:0] d;
    pin_in = 16'h1234; settle();
    rd(3'd0, d); check("R4 in0", d, 8'h34);
    rd(3'd1, d); check("R4/R5 in1 while pins are outputs", d, 8'h12);
    wr(3'd4, 8'hFF); wr(3'd5, 8'h0F);
    rd(3'd0, d); check("R4 in0 inverted", d, 8'hCB);
    rd(3'd1, d); check("R4 in1 half inverted", d, 8'h1D);
    rd(3'd5, d); check("R11 pol1 read", d, 8'h0F);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_ignore();
    logic [7:0] d;
    wr(3'd0, 8'h55); wr(3'd1, 8'hAA);
    check("R7 out unchanged", pin_out, 16'h3CA5);
    check("R7 oe unchanged", pin_oe, 16'hFFF0);
    rd(3'd4, d); check("R7 pol0 unchanged", d, 8'h00);
    rd(3'd7, d); check("R7 dir1 unchanged", d, 8'h00);
    rd(3'd0, d); check("R7 in0 still pins", d, 8'h34);
  endtask

  task automatic t_sync();
    pin_in = 16'h0000; settle();
    @(negedge clk); pin_in = 16'h00C3; rd_en = 1'b1; addr = 3'd0;
    @(negedge clk); rd_en = 1'b0;
    check("R10 first edge old", rdata, 8'h00);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R10 third edge new", rdata, 8'hC3);
  endtask

  task automatic t_hold();
    pin_in = 16'h00FF; settle();
    check("R9 rdata holds without rd_en", rdata, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_output();
    t_input();
    t_ignore();
    t_sync();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule